// File: doc/BRIEF.md
# Circular Receive Buffer Chunk Tracker

This block sits between a serial byte receiver and a circular receive buffer in memory. Every received byte is written at the current write offset, and the offset wraps to zero after the last slot. The block also works out when a consumer should take the bytes that have arrived. A report is made when the write offset crosses the buffer midpoint or the buffer end. A report is also made when the line has been quiet for a programmable number of tick pulses, so that a short message left in a partly filled buffer is still handed over.

Each report is a one-cycle strobe carrying a start offset, a byte length and a cause code. The block remembers where the previous report ended, so each report covers only the bytes that are new since that point. The idle input is taken at most once per burst of data. A countdown is started from it and counts down on an external tick. Any new byte stops the countdown and re-arms idle detection.

Top module: `rx_chunk_tracker`

## Requirements
- R1: Each cycle with `rx_valid_i` high drives `buf_we_o` high in that same cycle, with `buf_addr_o` equal to the current write offset and `buf_wdata_o` equal to `rx_data_i`. The offset then advances by one and goes from DEPTH-1 back to 0. Without a byte the offset holds.
- R2: A byte written to offset DEPTH/2-1 produces a report in the next cycle, with cause code 1 (half). Its start plus its length equals DEPTH/2.
- R3: A byte written to offset DEPTH-1 produces a report in the next cycle, with cause code 2 (full). Its start plus its length equals DEPTH. The next report then starts at offset 0.
- R4: `line_idle_i` is accepted only if at least one byte has arrived since the last acceptance. An idle pulse in the same cycle as a byte is ignored.
- R5: An accepted idle loads a countdown with `tmo_period_i`, and each `tick_i` pulse lowers it by one. One clock after the edge at which the countdown reads zero, a timeout report with cause code 3 is presented. A period of zero reports one clock after the idle is accepted.
- R6: A byte received while the countdown runs stops it, so no timeout report follows. Idle detection is armed again.
- R7: A timeout report starts at the end of the previous report and covers the bytes written since then. If that count is zero, no report is made.
- R8: `chunk_valid_o` is a pulse of one cycle for each report. Each report starts where the previous one ended, or at offset 0 after a full report.
- R9: While `rst_ni` is low, the write offset, the saved report position, the countdown and the idle-armed flag are cleared, and `chunk_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received byte present this cycle |
| rx_data_i | input | DATA_W | Received byte |
| line_idle_i | input | 1 | Idle-line indication from the receiver |
| tick_i | input | 1 | Timebase pulse for the countdown |
| tmo_period_i | input | TMO_W | Countdown period in ticks |
| buf_we_o | output | 1 | Buffer write enable |
| buf_addr_o | output | AW | Buffer write offset |
| buf_wdata_o | output | DATA_W | Buffer write data |
| chunk_valid_o | output | 1 | Report strobe |
| chunk_start_o | output | AW | First offset of the reported chunk |
| chunk_len_o | output | AW+1 | Byte count of the reported chunk |
| chunk_cause_o | output | 2 | 1 half, 2 full, 3 timeout |

## Verification
Some properties are checked on every cycle. These are: the write offset steps or holds, half and full reports end exactly at the midpoint or the buffer end, lengths are never zero, successive reports are contiguous, a countdown starts only from an idle input taken without a byte, and a byte always leaves the countdown stopped. Other behaviours can only be shown by the directed scenarios, because each needs a planned history of bytes, idle pulses and ticks. These are: the exact cycle of a timeout report, a countdown cancelled by a late byte, an idle ignored when not armed or when it meets a byte, a zero-length timeout that is suppressed, and a period of zero.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_HALF = 2'd1,
    CAUSE_FULL = 2'd2,
    CAUSE_TMO  = 2'd3
  } cause_e;
endpackage

// File: rtl/rxc_wr_ptr.sv
module rxc_wr_ptr #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  output logic [AW-1:0] ptr_o,
  output logic          half_o,
  output logic          full_o
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [AW-1:0] HALF_IDX = AW'(DEPTH / 2 - 1);

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (push_i) ptr_q <= (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o  = ptr_q;
  assign half_o = push_i && (ptr_q == HALF_IDX);
  assign full_o = push_i && (ptr_q == LAST_IDX);
endmodule

// File: rtl/rxc_idle_timer.sv
module rxc_idle_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             cancel_i,
  input  logic             idle_i,
  input  logic             tick_i,
  input  logic [TMO_W-1:0] period_i,
  output logic             tmo_o,
  output logic             armed_o,
  output logic             counting_o
);
  logic             armed_q, counting_q;
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q    <= 1'b0;
      counting_q <= 1'b0;
      cnt_q      <= '0;
    end else if (push_i || cancel_i) begin
      // new data re-arms idle detection and kills any countdown
      armed_q    <= armed_q | push_i;
      counting_q <= 1'b0;
    end else if (idle_i && armed_q) begin
      armed_q    <= 1'b0;
      counting_q <= 1'b1;
      cnt_q      <= period_i;
    end else if (counting_q) begin
      if (cnt_q == '0)  counting_q <= 1'b0;
      else if (tick_i)  cnt_q      <= cnt_q - 1'b1;
    end
  end

  assign tmo_o      = counting_q && (cnt_q == '0) && !push_i && !cancel_i;
  assign armed_o    = armed_q;
  assign counting_o = counting_q;
endmodule

// File: rtl/rxc_chunk_calc.sv
module rxc_chunk_calc
  import rxc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          half_i,
  input  logic          full_i,
  input  logic          tmo_i,
  input  logic [AW-1:0] ptr_i,
  output logic          valid_o,
  output logic [AW-1:0] start_o,
  output logic [LW-1:0] len_o,
  output cause_e        cause_o
);
  localparam logic [LW-1:0] END_FULL = LW'(DEPTH);
  localparam logic [LW-1:0] END_HALF = LW'(DEPTH / 2);

  logic [AW-1:0] saved_q;
  logic [LW-1:0] end_c, len_c;
  cause_e        cause_c;
  logic          fire_c;

  always_comb begin
    end_c   = {1'b0, ptr_i};
    cause_c = CAUSE_NONE;
    if (full_i) begin
      end_c   = END_FULL;
      cause_c = CAUSE_FULL;
    end else if (half_i) begin
      end_c   = END_HALF;
      cause_c = CAUSE_HALF;
    end else if (tmo_i) begin
      cause_c = CAUSE_TMO;
    end
    len_c  = end_c - {1'b0, saved_q};
    fire_c = (cause_c != CAUSE_NONE) && (len_c != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      saved_q <= '0;
      valid_o <= 1'b0;
      start_o <= '0;
      len_o   <= '0;
      cause_o <= CAUSE_NONE;
    end else begin
      valid_o <= fire_c;
      if (fire_c) begin
        start_o <= saved_q;
        len_o   <= len_c;
        cause_o <= cause_c;
        saved_q <= full_i ? '0 : end_c[AW-1:0];
      end
    end
  end
endmodule

// File: rtl/rx_chunk_tracker.sv
module rx_chunk_tracker
  import rxc_pkg::*;
#(
  parameter  int DEPTH  = 16,
  parameter  int DATA_W = 8,
  parameter  int TMO_W  = 16,
  localparam int AW     = $clog2(DEPTH),
  localparam int LW     = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              line_idle_i,
  input  logic              tick_i,
  input  logic [TMO_W-1:0]  tmo_period_i,
  output logic              buf_we_o,
  output logic [AW-1:0]     buf_addr_o,
  output logic [DATA_W-1:0] buf_wdata_o,
  output logic              chunk_valid_o,
  output logic [AW-1:0]     chunk_start_o,
  output logic [LW-1:0]     chunk_len_o,
  output logic [1:0]        chunk_cause_o
);
  generate
    if (DEPTH < 2 || (DEPTH % 2) != 0) begin : g_bad_depth
      $error("DEPTH must be even and at least 2");
    end
  endgenerate

  logic [AW-1:0] ptr;
  logic          evt_half, evt_full, evt_tmo;
  logic          tmr_armed, tmr_counting;
  cause_e        cause;

  rxc_wr_ptr #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (rx_valid_i),
    .ptr_o  (ptr),
    .half_o (evt_half),
    .full_o (evt_full)
  );

  rxc_idle_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (rx_valid_i),
    .cancel_i   (evt_half | evt_full),
    .idle_i     (line_idle_i),
    .tick_i     (tick_i),
    .period_i   (tmo_period_i),
    .tmo_o      (evt_tmo),
    .armed_o    (tmr_armed),
    .counting_o (tmr_counting)
  );

  rxc_chunk_calc #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_calc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .half_i  (evt_half),
    .full_i  (evt_full),
    .tmo_i   (evt_tmo),
    .ptr_i   (ptr),
    .valid_o (chunk_valid_o),
    .start_o (chunk_start_o),
    .len_o   (chunk_len_o),
    .cause_o (cause)
  );

  assign buf_we_o      = rx_valid_i;
  assign buf_addr_o    = ptr;
  assign buf_wdata_o   = rx_data_i;
  assign chunk_cause_o = cause;
endmodule

// File: rtl/rxc_checker.sv
module rxc_checker #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = AW + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_valid_i,
  input logic          line_idle_i,
  input logic [AW-1:0] buf_addr_o,
  input logic          chunk_valid_o,
  input logic [AW-1:0] chunk_start_o,
  input logic [LW-1:0] chunk_len_o,
  input logic [1:0]    chunk_cause_o,
  input logic          tmr_counting
);
  logic [AW-1:0] nxt_addr;
  logic [AW-1:0] exp_start;
  logic [LW-1:0] chunk_end;

  assign nxt_addr  = (buf_addr_o == AW'(DEPTH - 1)) ? '0 : buf_addr_o + 1'b1;
  assign chunk_end = {1'b0, chunk_start_o} + chunk_len_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) exp_start <= '0;
    else if (chunk_valid_o)
      exp_start <= (chunk_cause_o == 2'd2) ? '0 : chunk_end[AW-1:0];
  end

  assert_ptr_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> buf_addr_o == $past(nxt_addr));
  assert_ptr_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> $stable(buf_addr_o));
  assert_half_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chunk_valid_o && chunk_cause_o == 2'd1) |-> chunk_end == LW'(DEPTH / 2));
  assert_full_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chunk_valid_o && chunk_cause_o == 2'd2) |-> chunk_end == LW'(DEPTH));
  assert_idle_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmr_counting) |-> ($past(line_idle_i) && !$past(rx_valid_i)));
  assert_byte_stops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> !tmr_counting);
  assert_tmo_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chunk_valid_o && chunk_cause_o == 2'd3) |-> !$past(rx_valid_i));
  assert_nonzero_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chunk_valid_o |-> chunk_len_o != '0);
  assert_contiguous_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chunk_valid_o |-> chunk_start_o == exp_start);
endmodule

bind rx_chunk_tracker rxc_checker #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rx_valid_i    (rx_valid_i),
  .line_idle_i   (line_idle_i),
  .buf_addr_o    (buf_addr_o),
  .chunk_valid_o (chunk_valid_o),
  .chunk_start_o (chunk_start_o),
  .chunk_len_o   (chunk_len_o),
  .chunk_cause_o (chunk_cause_o),
  .tmr_counting  (tmr_counting)
);

// File: tb/tb_rx_chunk_tracker.sv
module tb_rx_chunk_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 8;
  localparam int TMO_W  = 8;
  localparam int AW     = $clog2(DEPTH);
  localparam int LW     = AW + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rx_valid = 1'b0;
  logic [DATA_W-1:0] rx_data = '0;
  logic              line_idle = 1'b0;
  logic              tick = 1'b0;
  logic [TMO_W-1:0]  period = '0;
  logic              buf_we;
  logic [AW-1:0]     buf_addr;
  logic [DATA_W-1:0] buf_wdata;
  logic              chunk_valid;
  logic [AW-1:0]     chunk_start;
  logic [LW-1:0]     chunk_len;
  logic [1:0]        chunk_cause;

  int n_tests = 0, n_fail = 0;
  int rpt_n = 0, base_n = 0;
  int last_start = 0, last_len = 0, last_cause = 0;
  int exp_ptr = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_chunk_tracker #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TMO_W(TMO_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .line_idle_i(line_idle), .tick_i(tick), .tmo_period_i(period),
    .buf_we_o(buf_we), .buf_addr_o(buf_addr), .buf_wdata_o(buf_wdata),
    .chunk_valid_o(chunk_valid), .chunk_start_o(chunk_start),
    .chunk_len_o(chunk_len), .chunk_cause_o(chunk_cause)
  );

  // report monitor: one sample per cycle, so a pulse counts once
  always @(negedge clk) begin
    if (rst_n && chunk_valid) begin
      rpt_n      <= rpt_n + 1;
      last_start <= int'(chunk_start);
      last_len   <= int'(chunk_len);
      last_cause <= int'(chunk_cause);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push(input logic [DATA_W-1:0] d);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = d;
    #1;
    check(buf_we && buf_wdata == d, "R1 write strobe/data", int'(buf_wdata), int'(d));
    check(int'(buf_addr) == exp_ptr, "R1 write offset", int'(buf_addr), exp_ptr);
    exp_ptr = (exp_ptr + 1) % DEPTH;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic idle_pulse();
    @(negedge clk);
    line_idle = 1'b1;
    @(negedge clk);
    line_idle = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic mark();
    #1;
    base_n = rpt_n;
  endtask

  task automatic expect_none(input string req);
    #1;
    check(rpt_n == base_n, req, rpt_n - base_n, 0);
  endtask

  task automatic expect_one(input string req, input int s, input int l, input int c);
    #1;
    check(rpt_n == base_n + 1, {req, " count"}, rpt_n - base_n, 1);
    check(last_start == s, {req, " start"}, last_start, s);
    check(last_len == l, {req, " length"}, last_len, l);
    check(last_cause == c, {req, " cause"}, last_cause, c);
  endtask

  task automatic test_reset();
    #1;
    check(!chunk_valid, "R9 valid low in reset", int'(chunk_valid), 0);
    check(buf_addr == '0, "R9 offset zero in reset", int'(buf_addr), 0);
    check(!buf_we, "R9 no write in reset", int'(buf_we), 0);
  endtask

  task automatic test_timeout_partial();
    period = 8'd4;
    mark();
    push(8'h11); push(8'h12); push(8'h13);
    idle_pulse();
    ticks(3);
    wait_cyc(3);
    expect_none("R5 no report before count ends");
    ticks(1);
    wait_cyc(2);
    expect_one("R5 R7 timeout chunk", 0, 3, 3);
  endtask

  task automatic test_idle_once();
    mark();
    idle_pulse();
    ticks(6);
    wait_cyc(3);
    expect_none("R4 idle ignored without new data");
  endtask

  task automatic test_cancel();
    mark();
    push(8'h21); push(8'h22);
    idle_pulse();
    ticks(2);
    push(8'h23);
    ticks(6);
    wait_cyc(3);
    expect_none("R6 byte cancels countdown");
    idle_pulse();
    ticks(4);
    wait_cyc(2);
    expect_one("R6 rearmed timeout", 3, 3, 3);
  endtask

  task automatic test_half();
    mark();
    push(8'h31);
    expect_none("R2 no report before midpoint");
    push(8'h32);
    expect_one("R2 half chunk", 6, 2, 1);
  endtask

  task automatic test_zero_len();
    mark();
    idle_pulse();
    ticks(4);
    wait_cyc(3);
    expect_none("R7 zero length suppressed");
  endtask

  task automatic test_full_wrap();
    mark();
    for (int i = 0; i < DEPTH / 2; i++) push(8'h40 + 8'(i));
    expect_one("R3 full chunk", 8, 8, 2);
    check(exp_ptr == 0, "R1 wrap model", exp_ptr, 0);
  endtask

  task automatic test_idle_with_byte();
    mark();
    @(negedge clk);
    rx_valid  = 1'b1;
    rx_data   = 8'h55;
    line_idle = 1'b1;
    #1;
    check(int'(buf_addr) == 0, "R1 offset after wrap", int'(buf_addr), 0);
    exp_ptr = 1;
    @(negedge clk);
    rx_valid  = 1'b0;
    line_idle = 1'b0;
    ticks(6);
    wait_cyc(3);
    expect_none("R4 idle with byte ignored");
    idle_pulse();
    ticks(4);
    wait_cyc(2);
    expect_one("R3 R8 next chunk from zero", 0, 1, 3);
  endtask

  task automatic test_period_zero();
    period = '0;
    mark();
    push(8'h61); push(8'h62);
    idle_pulse();
    wait_cyc(1);
    expect_one("R5 zero period", 1, 2, 3);
    wait_cyc(3);
    check(rpt_n == base_n + 1, "R8 single pulse", rpt_n - base_n, 1);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait_cyc(3);
    test_reset();
    @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(2);
    test_timeout_partial();
    test_idle_once();
    test_cancel();
    test_half();
    test_zero_len();
    test_full_wrap();
    test_idle_with_byte();
    test_period_zero();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule